// File: doc/BRIEF.md
# Sequential Access Circular Buffer

This block is a storage buffer that is always treated as full and is walked in strict circular order, with no row address anywhere. A single set bit circulating in a ring register picks the active row, and a small position counter advances with it. Every row is one wide word holding four lanes side by side, so a whole saved state of four values is moved in one access and no lane selection is needed.

Each accepted access is a read-then-write of the active row. The row's previous contents come out on `rd_data` one cycle later, the four new lanes go into the row, and the ring moves on by one row. Because the rows are visited in a fixed cycle, the value returned is always the one written `DEPTH` accepted accesses earlier. This suits a datapath that parks the state of a paused computation and picks it up again one full lap later. The rows are split evenly across `BANKS` storage banks, with rows numbered in order across the banks.

A small two-state controller tracks whether a full lap has been written since reset. In `ST_FILL` the row contents are undefined. The transition `ST_FILL -> ST_PRIMED` is taken on the access that writes the last row of the first lap. `ST_PRIMED` is held until reset. While `sleep` is high, access strokes are refused and reported on `err`.

Top module: `seq_ring_buffer`

## Requirements
- R1: After reset, `pos` is 0, `primed` is low, `err` is low and `rd_data` is all zeros.
- R2: The internal row-select ring always holds exactly one set bit, and that bit is the row numbered `pos`.
- R3: Each accepted access (`acc_req` high while `sleep` is low at a clock edge) advances `pos` by one after that edge, and `DEPTH-1` is followed by 0.
- R4: An accepted access stores `wr_data` into the active row. After the edge, `rd_data` shows what that row held before the access, which is the `wr_data` of the accepted access made `DEPTH` accepted accesses earlier.
- R5: `primed` rises after the `DEPTH`-th accepted access since reset (transition `ST_FILL -> ST_PRIMED`) and stays high until reset.
- R6: An access attempted while `sleep` is high changes neither the storage, `pos` nor `rd_data`, and `err` is high for exactly the one cycle after that edge.
- R7: In a cycle without `acc_req`, `pos` and `rd_data` hold and `err` is low after the edge.
- R8: Lane k of a row occupies bits `[k*DATA_W +: DATA_W]` of `wr_data` and `rd_data` (lane 0 in the lowest bits), and each lane is returned unchanged and independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_req | input | 1 | Read-then-write strobe for the active row |
| sleep | input | 1 | Low-power request; refuses accesses while high |
| wr_data | input | LANES*DATA_W | Four lanes of new state to store |
| rd_data | output | LANES*DATA_W | Previous contents of the row last accessed |
| pos | output | $clog2(DEPTH) | Position of the active row |
| primed | output | 1 | High once a full lap has been written |
| err | output | 1 | One-cycle flag for a refused access |

## Verification
The buffer is driven with back-to-back accesses over several laps, which separates a correct lap length and wrap from off-by-one or mis-rotated pointers. It is also driven with accesses broken up by idle cycles, which shows that only strokes advance the ring and that `rd_data` holds. Accesses attempted under `sleep` are placed in the middle of a lap and followed by normal reads of the rows they could have damaged, which exposes writes or pointer moves that leak through. Complementary lane patterns, with all-ones and all-zeros lanes next to each other, show whether the lanes are swapped or mixed.

// File: rtl/srb_pkg.sv
package srb_pkg;
    typedef enum logic [0:0] {
        ST_FILL   = 1'b0,
        ST_PRIMED = 1'b1
    } srb_state_e;
endpackage

// File: rtl/srb_ring_ptr.sv
module srb_ring_ptr #(
    parameter int DEPTH = 16,
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [DEPTH-1:0] sel,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] LAST = POS_W'(DEPTH - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel <= DEPTH'(1);
            pos <= '0;
        end else if (step) begin
            sel <= {sel[DEPTH-2:0], sel[DEPTH-1]};
            pos <= (pos == LAST) ? '0 : pos + 1'b1;
        end
    end

    // R2: a single set bit at every moment
    assert_ptr_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel) == 1);
    // R2: ring bit and counter agree
    assert_ptr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel[pos] == 1'b1);
    // R3: a step rotates the ring by one row
    assert_ptr_rotate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> sel == {$past(sel[DEPTH-2:0]), $past(sel[DEPTH-1])});
    // R7: no step, no movement
    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(sel) && $stable(pos));
endmodule

// File: rtl/srb_bank.sv
module srb_bank #(
    parameter int ROWS   = 8,
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROWS-1:0]   row_sel,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < ROWS; i++) begin
            if (wr_en && row_sel[i]) mem[i] <= wr_word;
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < ROWS; i++) begin
            if (row_sel[i]) rd_word = rd_word | mem[i];
        end
    end

    // R2: at most one row of this bank is ever active
    assert_bank_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_sel));
endmodule

// File: rtl/srb_ctrl.sv
module srb_ctrl
    import srb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_req,
    input  logic             sleep,
    input  logic [POS_W-1:0] pos,
    output logic             go,
    output logic             primed,
    output logic             err
);
    localparam logic [POS_W-1:0] LAST = POS_W'(DEPTH - 1);

    srb_state_e state, state_nx;

    assign go = acc_req && !sleep;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL:   if (go && pos == LAST) state_nx = ST_PRIMED;
            ST_PRIMED: state_nx = ST_PRIMED;
            default:   state_nx = ST_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FILL;
            err   <= 1'b0;
        end else begin
            state <= state_nx;
            err   <= acc_req && sleep;
        end
    end

    always_comb begin
        primed = (state == ST_PRIMED);
    end

    // R5: once primed, stays primed
    assert_primed_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(primed));
    // R6: refused stroke is flagged next cycle
    assert_err_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && sleep) |=> err);
    // R7: no stroke, no flag
    assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |=> !err);
endmodule

// File: rtl/seq_ring_buffer.sv
module seq_ring_buffer #(
    parameter int DEPTH  = 16,
    parameter int BANKS  = 2,
    parameter int LANES  = 4,
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc_req,
    input  logic                      sleep,
    input  logic [LANES*DATA_W-1:0]   wr_data,
    output logic [LANES*DATA_W-1:0]   rd_data,
    output logic [$clog2(DEPTH)-1:0]  pos,
    output logic                      primed,
    output logic                      err
);
    localparam int POS_W  = $clog2(DEPTH);
    localparam int WORD_W = LANES * DATA_W;
    localparam int ROWS_B = DEPTH / BANKS;

    logic              go;
    logic [DEPTH-1:0]  sel;
    logic [WORD_W-1:0] bank_rd [BANKS];
    logic [WORD_W-1:0] row_old;

    srb_ctrl #(.DEPTH(DEPTH), .POS_W(POS_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .sleep(sleep),
        .pos(pos), .go(go), .primed(primed), .err(err)
    );

    srb_ring_ptr #(.DEPTH(DEPTH), .POS_W(POS_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .step(go), .sel(sel), .pos(pos)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        srb_bank #(.ROWS(ROWS_B), .WORD_W(WORD_W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .row_sel(sel[b*ROWS_B +: ROWS_B]),
            .wr_en(go), .wr_word(wr_data), .rd_word(bank_rd[b])
        );
    end

    always_comb begin
        row_old = '0;
        for (int b = 0; b < BANKS; b++) row_old = row_old | bank_rd[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rd_data <= '0;
        else if (go) rd_data <= row_old;
    end

    // R6: refused stroke leaves the visible state alone
    assert_sleep_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && sleep) |=> $stable(pos) && $stable(rd_data));
    // R3: accepted stroke moves the position
    assert_pos_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> pos != $past(pos));
endmodule

// File: tb/seq_ring_buffer_bench.sv
`timescale 1ns/1ps
module seq_ring_buffer_bench;
    localparam int DEPTH  = 16;
    localparam int BANKS  = 2;
    localparam int LANES  = 4;
    localparam int DATA_W = 16;
    localparam int WW     = LANES * DATA_W;
    localparam int PW     = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_req = 1'b0;
    logic          sleep = 1'b0;
    logic [WW-1:0] wr_data = '0;
    logic [WW-1:0] rd_data;
    logic [PW-1:0] pos;
    logic          primed, err;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    seq_ring_buffer #(.DEPTH(DEPTH), .BANKS(BANKS), .LANES(LANES), .DATA_W(DATA_W))
    u_seq_ring_buffer (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .sleep(sleep),
        .wr_data(wr_data), .rd_data(rd_data), .pos(pos),
        .primed(primed), .err(err)
    );

    // reference model
    logic [WW-1:0] hist[$];
    int            m_pos = 0;
    int            m_cnt = 0;
    logic [WW-1:0] m_rd = '0;
    bit            m_rd_known = 1'b1;
    bit            m_err = 1'b0;

    task automatic check(string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all(bit was_acc, bit was_slp);
        string ptag;
        ptag = (was_acc && !was_slp) ? "R3" : (was_acc ? "R6" : "R7");
        check(ptag, WW'(pos), WW'(m_pos));
        check("R5", WW'(primed), WW'(m_cnt >= DEPTH));
        check(was_acc ? "R6" : "R7", WW'(err), WW'(m_err));
        if (m_rd_known) begin
            check(was_acc && !was_slp ? "R4" : "R7", rd_data, m_rd);
            for (int l = 0; l < LANES; l++)
                check("R8", WW'(rd_data[l*DATA_W +: DATA_W]), WW'(m_rd[l*DATA_W +: DATA_W]));
        end
    endtask

    task automatic step(bit a, bit s, logic [WW-1:0] d);
        acc_req = a; sleep = s; wr_data = d;
        @(posedge clk);
        m_err = a && s;
        if (a && !s) begin
            if (hist.size() == DEPTH) begin
                m_rd = hist.pop_front();
                m_rd_known = 1'b1;
            end else begin
                m_rd_known = 1'b0;
            end
            hist.push_back(d);
            m_pos = (m_pos + 1) % DEPTH;
            m_cnt++;
        end
        @(negedge clk);
        compare_all(a, s);
    endtask

    function automatic logic [WW-1:0] mk(int k);
        logic [WW-1:0] w;
        for (int l = 0; l < LANES; l++)
            w[l*DATA_W +: DATA_W] = DATA_W'((k * 37 + l * 4099) ^ (l << 12));
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values, checked while reset is still applied
        check("R1", WW'(pos), '0);
        check("R1", WW'(primed), '0);
        check("R1", WW'(err), '0);
        check("R1", rd_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", rd_data, '0);
        // first lap: fill, R5 flips at the last row
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, mk(i));
        // back-to-back laps, R4 returns one lap old
        for (int i = 0; i < 2 * DEPTH; i++) step(1'b1, 1'b0, mk(100 + i));
        // sparse strokes with idles, R7 hold
        for (int i = 0; i < 24; i++) step(i % 3 == 0, 1'b0, mk(300 + i));
        // refused strokes under sleep mid-lap, R6
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, {WW{1'b1}});
        step(1'b0, 1'b1, mk(7));
        step(1'b0, 1'b0, mk(8));
        // read back rows the refused strokes could have hit
        for (int i = 0; i < DEPTH + 3; i++) step(1'b1, 1'b0, mk(500 + i));
        // complementary lane patterns, R8
        for (int i = 0; i < 2 * DEPTH; i++)
            step(1'b1, 1'b0, (i % 2) ? {{DATA_W{1'b1}}, {DATA_W{1'b0}}, {DATA_W{1'b1}}, {DATA_W{1'b0}}}
                                     : {{DATA_W{1'b0}}, {DATA_W{1'b1}}, {DATA_W{1'b0}}, {DATA_W{1'b1}}});
        // interleaved sleep and accepted strokes
        for (int i = 0; i < 20; i++) step(1'b1, i % 2 == 1, mk(700 + i));
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule